// File: doc/BRIEF.md
# Multi-Level Daisy-Chain Bus Arbiter

This block decides which of several bus masters may drive a shared bus. The masters sit in a chain. Index 0 is nearest the central grant source and the highest index is farthest from it. Each master owns a static level number, held in a register inside the block. A request travels along the chain on the wire pair for its master's level. The nearest requester on a level blocks every requester behind it on that level. A request on a higher level skips past nearer masters that sit on lower levels. This gives a limited, loadable priority scheme while keeping position-based priority inside each level.

The block issues a new grant only when the bus is reported free and no grant is outstanding. The winner keeps its one-hot grant for as long as it holds its request. The grant drops on the first clock edge after the request falls, and the next grant can come one edge after that.

All pins are plain control pins. No data moves through the block, so there is no valid/ready interface. Level values at or above `NUM_LVL` (possible when `NUM_LVL` is not a power of two) match no level, so that master is never granted.

Top module: `mlvl_chain_arb`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `gnt` is all zero. Every master's level register resets to 0.
- R2: At most one bit of `gnt` is high in any cycle.
- R3: A new grant is loaded only on a clock edge where `bus_busy` is low and `gnt` is all zero. It appears on `gnt` one edge after the request pattern is sampled. While `bus_busy` is high and no grant is held, `gnt` stays zero.
- R4: Among the masters that are requesting, only those on the highest requested level are candidates. Master i's level is field `lvl_wr_data[i*LVL_W +: LVL_W]`, read as an unsigned number, and a larger value means higher priority.
- R5: Within the winning level, the requesting master with the lowest index wins, whatever the requests farther along the chain.
- R6: While the granted master keeps its `req` bit high, `gnt` does not change, whatever the other requests or `bus_busy` do.
- R7: On the first edge after the granted master's `req` bit is low, `gnt` returns to zero. A new grant can appear no earlier than the following edge.
- R8: A level write (`lvl_wr_en` high) takes effect on the clock edge only if `bus_busy` is low and `gnt` is all zero. Otherwise it is ignored and the previous levels stay in force.
- R9: A request pattern of all zeros never produces a grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_DEV | Per-master bus request; bit i belongs to chain position i |
| bus_busy | input | 1 | High while a transaction occupies the bus; blocks new grants and level writes |
| lvl_wr_en | input | 1 | Load strobe for the per-master level register |
| lvl_wr_data | input | NUM_DEV*LVL_W | Packed level values; master i at bits [i*LVL_W +: LVL_W] |
| gnt | output | NUM_DEV | One-hot (or zero) registered grant |

## Verification
The bench builds the arbiter with four masters and four levels. At that size every one of the 256 level assignments can be combined with every one of the 16 request patterns. This covers every tie inside a level, every bypass of a nearer master by a farther one on a higher level, and the all-idle pattern. Directed sequences cover the cases the sweep does not:
- a busy bus blocking a grant;
- a held grant ignoring new higher-priority requests;
- the one-cycle gap after release;
- level writes that are refused because the bus is busy or a grant is held.

// File: rtl/mca_pkg.sv
package mca_pkg;
  // Ownership of the bus as seen by the grant controller
  typedef enum logic {
    OWN_NONE = 1'b0,
    OWN_HELD = 1'b1
  } own_e;

  // Width of a level field for a given level count
  function automatic int lvl_bits(input int n_lvl);
    return (n_lvl > 1) ? $clog2(n_lvl) : 1;
  endfunction
endpackage

// File: rtl/mca_lvl_regs.sv
module mca_lvl_regs #(
  parameter int NUM_DEV = 8,
  parameter int LVL_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_ok,
  input  logic [NUM_DEV*LVL_W-1:0] wr_data,
  output logic [NUM_DEV*LVL_W-1:0] lvl_q
);
  localparam int TOT_W = NUM_DEV * LVL_W;

  // Static level assignment; a write is taken only in an idle bus window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (wr_en && wr_ok) begin
      lvl_q <= wr_data[TOT_W-1:0];
    end
  end
endmodule

// File: rtl/mca_chain.sv
module mca_chain #(
  parameter int NUM_DEV = 8,
  parameter int LVL_W   = 2,
  parameter int LVL_ID  = 0
) (
  input  logic [NUM_DEV-1:0]       req,
  input  logic [NUM_DEV*LVL_W-1:0] lvl_q,
  output logic [NUM_DEV-1:0]       win,
  output logic                     any
);
  localparam logic [LVL_W-1:0] MY_LVL = LVL_W'(LVL_ID);

  logic [NUM_DEV-1:0] member;
  logic [NUM_DEV:0]   pass;   // grant token rippling away from the source

  assign pass[0] = 1'b1;

  // One link per chain position: take the token if requesting on this level,
  // otherwise hand it on to the next, more distant, position.
  for (genvar i = 0; i < NUM_DEV; i++) begin : g_link
    assign member[i]  = req[i] && (lvl_q[i*LVL_W +: LVL_W] == MY_LVL);
    assign win[i]     = pass[i] & member[i];
    assign pass[i+1]  = pass[i] & ~member[i];
  end

  // Token consumed somewhere means this level carries a request
  assign any = ~pass[NUM_DEV];
endmodule

// File: rtl/mca_lvl_pick.sv
module mca_lvl_pick #(
  parameter int NUM_DEV = 8,
  parameter int NUM_LVL = 4
) (
  input  logic [NUM_LVL*NUM_DEV-1:0] win_all,
  input  logic [NUM_LVL-1:0]         any,
  output logic [NUM_DEV-1:0]         pick
);
  // Scan upward so the highest active level overrides lower ones
  always_comb begin
    pick = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (any[l]) begin
        pick = win_all[l*NUM_DEV +: NUM_DEV];
      end
    end
  end
endmodule

// File: rtl/mca_gnt_ctl.sv
module mca_gnt_ctl
  import mca_pkg::*;
#(
  parameter int NUM_DEV = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] req,
  input  logic               bus_busy,
  input  logic [NUM_DEV-1:0] pick,
  output logic [NUM_DEV-1:0] gnt,
  output logic               idle
);
  own_e own_q;
  logic owner_live;

  assign owner_live = |(gnt & req);
  assign idle       = (own_q == OWN_NONE) && !bus_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q <= OWN_NONE;
      gnt   <= '0;
    end else begin
      case (own_q)
        OWN_HELD: begin
          if (!owner_live) begin
            own_q <= OWN_NONE;
            gnt   <= '0;
          end
        end
        default: begin
          if (!bus_busy && (|pick)) begin
            own_q <= OWN_HELD;
            gnt   <= pick;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mlvl_chain_arb.sv
module mlvl_chain_arb #(
  parameter int NUM_DEV = 8,
  parameter int NUM_LVL = 4,
  parameter int LVL_W   = mca_pkg::lvl_bits(NUM_LVL)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_DEV-1:0]       req,
  input  logic                     bus_busy,
  input  logic                     lvl_wr_en,
  input  logic [NUM_DEV*LVL_W-1:0] lvl_wr_data,
  output logic [NUM_DEV-1:0]       gnt
);
  localparam int WIN_W = NUM_LVL * NUM_DEV;

  logic [NUM_DEV*LVL_W-1:0] lvl_q;
  logic [WIN_W-1:0]         win_all;
  logic [NUM_LVL-1:0]       lvl_any;
  logic [NUM_DEV-1:0]       pick;
  logic                     idle;

  mca_lvl_regs #(.NUM_DEV(NUM_DEV), .LVL_W(LVL_W)) u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (lvl_wr_en),
    .wr_ok   (idle),
    .wr_data (lvl_wr_data),
    .lvl_q   (lvl_q)
  );

  // One independent request/grant chain per level
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    mca_chain #(.NUM_DEV(NUM_DEV), .LVL_W(LVL_W), .LVL_ID(l)) u_chain (
      .req   (req),
      .lvl_q (lvl_q),
      .win   (win_all[l*NUM_DEV +: NUM_DEV]),
      .any   (lvl_any[l])
    );
  end

  mca_lvl_pick #(.NUM_DEV(NUM_DEV), .NUM_LVL(NUM_LVL)) u_pick (
    .win_all (win_all),
    .any     (lvl_any),
    .pick    (pick)
  );

  mca_gnt_ctl #(.NUM_DEV(NUM_DEV)) u_gnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .bus_busy (bus_busy),
    .pick     (pick),
    .gnt      (gnt),
    .idle     (idle)
  );
endmodule

// File: rtl/mca_checker.sv
module mca_checker #(
  parameter int NUM_DEV = 8,
  parameter int LVL_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_DEV-1:0]       req,
  input logic                     bus_busy,
  input logic [NUM_DEV-1:0]       gnt,
  input logic [NUM_DEV*LVL_W-1:0] lvl_q
);
  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && bus_busy) |=> (gnt == '0));

  p_grant_to_requester_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) |=> (gnt == '0 || (gnt & $past(req)) != '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && (gnt & req) != '0) |=> $stable(gnt));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && (gnt & req) == '0) |=> (gnt == '0));

  p_lvl_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy || gnt != '0) |=> $stable(lvl_q));

  p_no_req_no_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && req == '0) |=> (gnt == '0));
endmodule

bind mlvl_chain_arb mca_checker #(.NUM_DEV(NUM_DEV), .LVL_W(LVL_W)) u_mca_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .bus_busy (bus_busy),
  .gnt      (gnt),
  .lvl_q    (lvl_q)
);

// File: tb/test_mlvl_chain_arb.sv
module test_mlvl_chain_arb;
  localparam int ND = 4;
  localparam int NL = 4;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [ND-1:0] req = '0;
  logic          bus_busy = 1'b0;
  logic          lvl_wr_en = 1'b0;
  logic [ND*LW-1:0] lvl_wr_data = '0;
  logic [ND-1:0] gnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  mlvl_chain_arb #(.NUM_DEV(ND), .NUM_LVL(NL), .LVL_W(LW)) i_mlvl_chain_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .bus_busy(bus_busy),
    .lvl_wr_en(lvl_wr_en), .lvl_wr_data(lvl_wr_data), .gnt(gnt)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [ND-1:0] act, input logic [ND-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: gnt=%b expected %b", tag, act, exp);
    end
  endtask

  // Highest level first, then nearest position
  function automatic logic [ND-1:0] model(input logic [ND-1:0] r, input logic [ND*LW-1:0] lv);
    for (int l = NL - 1; l >= 0; l--)
      for (int i = 0; i < ND; i++)
        if (r[i] && lv[i*LW +: LW] == LW'(l)) return ND'(1) << i;
    return '0;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_lvl(input logic [ND*LW-1:0] v);
    lvl_wr_en = 1'b1; lvl_wr_data = v;
    tick();
    lvl_wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) tick();
    chk("R1 in reset", gnt, '0);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", gnt, '0);
    // Levels reset to 0: all on one level, nearest wins
    req = 4'b1010; tick();
    chk("R1 R5 reset levels", gnt, 4'b0010);
    req = '0; tick();
    chk("R7 release", gnt, '0);

    // Exhaustive sweep of level maps and request patterns
    for (int a = 0; a < 256; a++) begin
      for (int p = 0; p < 16; p++) begin
        write_lvl(8'(a));
        req = 4'(p); tick();
        chk((p == 0) ? "R9 no request" : "R4 R5 sweep", gnt, model(4'(p), 8'(a)));
        req = '0; tick();
        chk("R7 sweep release", gnt, '0);
      end
    end

    // R3: busy bus blocks a new grant
    write_lvl(8'h00);
    bus_busy = 1'b1; req = 4'b0101;
    tick(); chk("R3 busy blocks", gnt, '0);
    tick(); chk("R3 busy blocks 2", gnt, '0);
    bus_busy = 1'b0; tick();
    chk("R3 grant after busy", gnt, 4'b0001);
    req = '0; tick();

    // R6: held grant ignores others and busy
    write_lvl(8'h00);
    req = 4'b0100; tick();
    chk("R6 initial", gnt, 4'b0100);
    req = 4'b1111; bus_busy = 1'b1; tick();
    chk("R6 hold busy", gnt, 4'b0100);
    bus_busy = 1'b0; tick();
    chk("R6 hold others", gnt, 4'b0100);
    // R7: drop owner, gap cycle, then new grant
    req = 4'b0010; tick();
    chk("R7 gap", gnt, '0);
    tick();
    chk("R7 next grant", gnt, 4'b0010);
    req = '0; tick();

    // R8: write refused while a grant is held
    write_lvl(8'h00);
    req = 4'b1000; tick();
    chk("R8 setup", gnt, 4'b1000);
    write_lvl(8'hC0);          // would put master 3 on level 3
    req = '0; tick();
    req = 4'b1001; tick();
    chk("R8 write ignored when granted", gnt, 4'b0001);
    req = '0; tick();
    // R8: write refused while bus busy
    bus_busy = 1'b1; write_lvl(8'hC0); bus_busy = 1'b0;
    req = 4'b1001; tick();
    chk("R8 write ignored when busy", gnt, 4'b0001);
    req = '0; tick();
    // R8: accepted when idle
    write_lvl(8'hC0);
    req = 4'b1001; tick();
    chk("R8 R4 write accepted idle", gnt, 4'b1000);
    req = '0; tick();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule